// File: doc/BRIEF.md
# Instruction Prefetch Queue

This block is a byte-wide first-in first-out buffer that sits between a bus fetch engine and an instruction decoder. The fetch side is offered a 16-bit word whenever at least two byte slots are free. The block keeps its own fetch address, and the first word after an odd start address yields only its upper byte. The drain side sees the six oldest bytes at once together with a count of how many of them are valid. In one cycle it may retire any number from one to six of them, so an instruction of any length leaves the queue in a single step.

A control transfer uses the flush input. Flush drops every buffered byte at once and loads a new fetch address, and fetching resumes from there on the next cycle. The consumer watches the valid count and waits until a whole instruction is present. A pop request for more bytes than are valid does nothing.

Top module: `instr_prefetch_queue`

## Requirements
- R1: While reset is asserted, and right after it is released, the valid count is 0, the fetch address is 0 and the fetch request is high.
- R2: The fetch request is high exactly when the valid count is at most DEPTH-2 (4 by default).
- R3: A word offered while the request is high, with an even fetch address, appends its low byte and then its high byte. The fetch address then advances by 2.
- R4: A word offered while the request is high, with an odd fetch address, appends only its upper byte (bits 15:8). The fetch address then advances by 1.
- R5: A word offered while the request is low changes neither the queue nor the fetch address.
- R6: Bytes leave in the order they were appended. Head byte i sits at bits [8i+7:8i], the oldest at i=0, and the valid count reports how many head bytes are meaningful.
- R7: A pop of n bytes, with n from 1 to the valid count (at most 6), removes the n oldest bytes in one cycle.
- R8: A pop of 0 bytes, or of more bytes than are valid, is ignored.
- R9: When a pop and a fetched word fall in the same cycle, the new count is the old count minus the popped bytes plus the appended bytes, and the new bytes follow the remaining ones.
- R10: Flush empties the queue in one cycle and loads the fetch address from the flush address. A word or pop in the same cycle is discarded.
- R11: The valid count never exceeds DEPTH (6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flush_i | input | 1 | Discard all bytes and reload the fetch address |
| flush_addr_i | input | ADDR_W (20) | Fetch address loaded on flush |
| fetch_req_o | output | 1 | Room for a full word is available |
| fetch_addr_o | output | ADDR_W (20) | Byte address of the next fetch |
| fetch_valid_i | input | 1 | Fetched word is present this cycle |
| fetch_data_i | input | 16 | Fetched word, lower address in bits 7:0 |
| head_bytes_o | output | DEPTH*8 (48) | Buffered bytes, oldest in bits 7:0 |
| count_o | output | CNT_W (3) | Number of valid head bytes |
| pop_i | input | 1 | Remove bytes this cycle |
| pop_cnt_i | input | CNT_W (3) | Number of bytes to remove |

## Verification
Popping and appending can fall in the same cycle. This is the case most likely to corrupt byte placement, because the new bytes have to land directly behind the bytes that remain after the shift. The bench provokes it by offering a word while popping, once so that the queue drains empty and refills in that cycle, and once so that only part of the queue is left. In both cases it compares the resulting count and every valid head byte against the order worked out by hand. Flush is also applied together with a word or a pop, and the bench then confirms an empty queue and the new address.

// File: rtl/ipq_pkg.sv
package ipq_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/ipq_rst_sync.sv
module ipq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync_o = sync_q[1];
endmodule

// File: rtl/ipq_fetch_ctrl.sv
module ipq_fetch_ctrl #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic [ADDR_W-1:0] flush_addr_i,
  input  logic              push_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              odd_o
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              addr_en;

  always_comb begin
    addr_en = flush_i || push_i;
    if (flush_i)     addr_d = flush_addr_i;
    else if (addr_q[0]) addr_d = addr_q + ADDR_W'(1);
    else             addr_d = addr_q + ADDR_W'(2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign addr_o = addr_q;
  assign odd_o  = addr_q[0];
endmodule

// File: rtl/ipq_occupancy.sv
module ipq_occupancy #(
  parameter int DEPTH = 6,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             pop_i,
  input  logic [CNT_W-1:0] pop_cnt_i,
  input  logic             push_i,
  input  logic             push_odd_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] pop_amt_o,
  output logic             req_o
);
  localparam logic [CNT_W-1:0] REQ_LIMIT = CNT_W'(DEPTH - 2);

  logic [CNT_W-1:0] count_q, count_d, push_amt;
  logic             pop_ok, count_en;

  always_comb begin
    pop_ok    = pop_i && (pop_cnt_i != '0) && (pop_cnt_i <= count_q);
    pop_amt_o = pop_ok ? pop_cnt_i : '0;
    push_amt  = !push_i ? '0 : (push_odd_i ? CNT_W'(1) : CNT_W'(2));
    count_en  = flush_i || pop_ok || push_i;
    if (flush_i) count_d = '0;
    else         count_d = count_q - pop_amt_o + push_amt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (count_en) count_q <= count_d;
  end

  assign count_o = count_q;
  assign req_o   = (count_q <= REQ_LIMIT);
endmodule

// File: rtl/ipq_byte_store.sv
module ipq_byte_store
  import ipq_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int CNT_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush_i,
  input  logic                    push_i,
  input  logic                    push_odd_i,
  input  logic [WORD_W-1:0]       word_i,
  input  logic [CNT_W-1:0]        count_i,
  input  logic [CNT_W-1:0]        pop_amt_i,
  output logic [DEPTH*BYTE_W-1:0] head_o
);
  byte_t            mem_q   [DEPTH];
  byte_t            mem_d   [DEPTH];
  byte_t            shift_s [DEPTH];
  logic [CNT_W-1:0] base;
  logic             write_en;

  always_comb begin
    base     = count_i - pop_amt_i;
    write_en = !flush_i && (push_i || (pop_amt_i != '0));
    for (int i = 0; i < DEPTH; i++) begin
      shift_s[i] = '0;
      for (int j = 0; j < DEPTH; j++) begin
        if (j == i + int'(pop_amt_i)) shift_s[i] = mem_q[j];
      end
    end
    for (int i = 0; i < DEPTH; i++) begin
      mem_d[i] = shift_s[i];
      if (push_i) begin
        if (i == int'(base))
          mem_d[i] = push_odd_i ? word_i[WORD_W-1:BYTE_W] : word_i[BYTE_W-1:0];
        else if (!push_odd_i && (i == int'(base) + 1))
          mem_d[i] = word_i[WORD_W-1:BYTE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (write_en) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_head
    assign head_o[g*BYTE_W +: BYTE_W] = mem_q[g];
  end
endmodule

// File: rtl/instr_prefetch_queue.sv
module instr_prefetch_queue
  import ipq_pkg::*;
#(
  parameter int DEPTH  = 6,
  parameter int ADDR_W = 20,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush_i,
  input  logic [ADDR_W-1:0]       flush_addr_i,
  output logic                    fetch_req_o,
  output logic [ADDR_W-1:0]       fetch_addr_o,
  input  logic                    fetch_valid_i,
  input  logic [WORD_W-1:0]       fetch_data_i,
  output logic [DEPTH*BYTE_W-1:0] head_bytes_o,
  output logic [CNT_W-1:0]        count_o,
  input  logic                    pop_i,
  input  logic [CNT_W-1:0]        pop_cnt_i
);
  logic             rst_n_int;
  logic             push, push_odd, req;
  logic [CNT_W-1:0] count, pop_amt;

  assign push = fetch_valid_i && req && !flush_i;

  ipq_rst_sync u_rst (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_n_sync_o (rst_n_int)
  );

  ipq_fetch_ctrl #(.ADDR_W(ADDR_W)) u_fetch (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .flush_i      (flush_i),
    .flush_addr_i (flush_addr_i),
    .push_i       (push),
    .addr_o       (fetch_addr_o),
    .odd_o        (push_odd)
  );

  ipq_occupancy #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_occ (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .flush_i    (flush_i),
    .pop_i      (pop_i),
    .pop_cnt_i  (pop_cnt_i),
    .push_i     (push),
    .push_odd_i (push_odd),
    .count_o    (count),
    .pop_amt_o  (pop_amt),
    .req_o      (req)
  );

  ipq_byte_store #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .flush_i    (flush_i),
    .push_i     (push),
    .push_odd_i (push_odd),
    .word_i     (fetch_data_i),
    .count_i    (count),
    .pop_amt_i  (pop_amt),
    .head_o     (head_bytes_o)
  );

  assign fetch_req_o = req;
  assign count_o     = count;
endmodule

// File: rtl/ipq_checker.sv
module ipq_checker #(
  parameter int DEPTH  = 6,
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                flush_i,
  input logic [ADDR_W-1:0]   flush_addr_i,
  input logic                fetch_req_o,
  input logic [ADDR_W-1:0]   fetch_addr_o,
  input logic                fetch_valid_i,
  input logic [DEPTH*8-1:0]  head_bytes_o,
  input logic [CNT_W-1:0]    count_o,
  input logic                pop_i,
  input logic [CNT_W-1:0]    pop_cnt_i
);
  logic took;
  assign took = fetch_valid_i && fetch_req_o && !flush_i;

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= CNT_W'(DEPTH));

  p_req_room_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req_o |-> (count_o <= CNT_W'(DEPTH - 2)));

  p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (count_o == '0) && (fetch_addr_o == $past(flush_addr_i)));

  p_even_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (took && !fetch_addr_o[0]) |=> fetch_addr_o == $past(fetch_addr_o) + ADDR_W'(2));

  p_odd_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (took && fetch_addr_o[0]) |=> fetch_addr_o == $past(fetch_addr_o) + ADDR_W'(1));

  p_refused_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid_i && !fetch_req_o && !flush_i && !pop_i) |=>
      $stable(count_o) && $stable(fetch_addr_o) && $stable(head_bytes_o));

  p_bad_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !flush_i && !took && ((pop_cnt_i == '0) || (pop_cnt_i > count_o))) |=>
      $stable(count_o) && $stable(head_bytes_o));

  p_pop_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !flush_i && !took && (pop_cnt_i == CNT_W'(1)) && (count_o >= CNT_W'(2))) |=>
      (head_bytes_o[7:0] == $past(head_bytes_o[15:8])) && (count_o == $past(count_o) - CNT_W'(1)));
endmodule

bind instr_prefetch_queue ipq_checker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .flush_i       (flush_i),
  .flush_addr_i  (flush_addr_i),
  .fetch_req_o   (fetch_req_o),
  .fetch_addr_o  (fetch_addr_o),
  .fetch_valid_i (fetch_valid_i),
  .head_bytes_o  (head_bytes_o),
  .count_o       (count_o),
  .pop_i         (pop_i),
  .pop_cnt_i     (pop_cnt_i)
);

// File: tb/instr_prefetch_queue_test.sv
module instr_prefetch_queue_test;
  localparam int  DEPTH  = 6;
  localparam int  ADDR_W = 20;
  localparam int  CNT_W  = 3;
  localparam time PERIOD = 20ns;

  typedef struct packed {
    logic              fl;
    logic [ADDR_W-1:0] fa;
    logic              fv;
    logic [15:0]       fd;
    logic              pp;
    logic [CNT_W-1:0]  pc;
    logic [CNT_W-1:0]  ec;
    logic [47:0]       eh;
    logic [ADDR_W-1:0] ea;
    logic              er;
  } vec_t;

  // fl fa fv fd pp pc | expected count head addr req
  localparam vec_t VEC [17] = '{
    '{1'b1, 20'h00101, 1'b0, 16'h0000, 1'b0, 3'd0, 3'd0, 48'h0,            20'h00101, 1'b1}, // R10 flush to odd
    '{1'b0, 20'h0,     1'b1, 16'hA1B2, 1'b0, 3'd0, 3'd1, 48'h0000000000A1, 20'h00102, 1'b1}, // R4 odd fetch
    '{1'b0, 20'h0,     1'b1, 16'hC3D4, 1'b0, 3'd0, 3'd3, 48'h000000C3D4A1, 20'h00104, 1'b1}, // R3 even fetch
    '{1'b0, 20'h0,     1'b1, 16'hE5F6, 1'b0, 3'd0, 3'd5, 48'h00E5F6C3D4A1, 20'h00106, 1'b0}, // R2 request drops
    '{1'b0, 20'h0,     1'b1, 16'h1111, 1'b0, 3'd0, 3'd5, 48'h00E5F6C3D4A1, 20'h00106, 1'b0}, // R5 refused word
    '{1'b0, 20'h0,     1'b0, 16'h0000, 1'b1, 3'd2, 3'd3, 48'h000000E5F6C3, 20'h00106, 1'b1}, // R7 pop two
    '{1'b0, 20'h0,     1'b1, 16'h2233, 1'b1, 3'd3, 3'd2, 48'h000000002233, 20'h00108, 1'b1}, // R9 drain and refill
    '{1'b0, 20'h0,     1'b0, 16'h0000, 1'b1, 3'd3, 3'd2, 48'h000000002233, 20'h00108, 1'b1}, // R8 pop too many
    '{1'b0, 20'h0,     1'b0, 16'h0000, 1'b1, 3'd0, 3'd2, 48'h000000002233, 20'h00108, 1'b1}, // R8 pop zero
    '{1'b0, 20'h0,     1'b1, 16'h4455, 1'b1, 3'd1, 3'd3, 48'h000000445522, 20'h0010A, 1'b1}, // R9 partial
    '{1'b0, 20'h0,     1'b1, 16'h6677, 1'b0, 3'd0, 3'd5, 48'h006677445522, 20'h0010C, 1'b0}, // R6 order
    '{1'b0, 20'h0,     1'b0, 16'h0000, 1'b1, 3'd1, 3'd4, 48'h000066774455, 20'h0010C, 1'b1}, // R7 pop one
    '{1'b0, 20'h0,     1'b1, 16'h8899, 1'b0, 3'd0, 3'd6, 48'h889966774455, 20'h0010E, 1'b0}, // R11 full
    '{1'b0, 20'h0,     1'b0, 16'h0000, 1'b1, 3'd6, 3'd0, 48'h0,            20'h0010E, 1'b1}, // R7 pop six
    '{1'b1, 20'h00200, 1'b1, 16'hAABB, 1'b0, 3'd0, 3'd0, 48'h0,            20'h00200, 1'b1}, // R10 flush beats word
    '{1'b0, 20'h0,     1'b1, 16'hCCDD, 1'b0, 3'd0, 3'd2, 48'h00000000CCDD, 20'h00202, 1'b1}, // R3 restart
    '{1'b1, 20'h00300, 1'b0, 16'h0000, 1'b1, 3'd1, 3'd0, 48'h0,            20'h00300, 1'b1}  // R10 flush beats pop
  };

  logic                    clk = 1'b0;
  logic                    rst_n;
  logic                    flush_i, fetch_valid_i, pop_i;
  logic [ADDR_W-1:0]       flush_addr_i;
  logic [15:0]             fetch_data_i;
  logic [CNT_W-1:0]        pop_cnt_i;
  logic                    fetch_req_o;
  logic [ADDR_W-1:0]       fetch_addr_o;
  logic [DEPTH*8-1:0]      head_bytes_o;
  logic [CNT_W-1:0]        count_o;

  int total = 0;
  int failed = 0;

  always #(PERIOD/2) clk = ~clk;

  instr_prefetch_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush_i       (flush_i),
    .flush_addr_i  (flush_addr_i),
    .fetch_req_o   (fetch_req_o),
    .fetch_addr_o  (fetch_addr_o),
    .fetch_valid_i (fetch_valid_i),
    .fetch_data_i  (fetch_data_i),
    .head_bytes_o  (head_bytes_o),
    .count_o       (count_o),
    .pop_i         (pop_i),
    .pop_cnt_i     (pop_cnt_i)
  );

  task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic logic [47:0] masked(input logic [47:0] h, input logic [CNT_W-1:0] n);
    logic [47:0] m = '0;
    for (int b = 0; b < DEPTH; b++) if (b < int'(n)) m[b*8 +: 8] = h[b*8 +: 8];
    return m;
  endfunction

  task automatic drive(input logic fl, input logic [ADDR_W-1:0] fa, input logic fv,
                       input logic [15:0] fd, input logic pp, input logic [CNT_W-1:0] pc);
    flush_i = fl; flush_addr_i = fa; fetch_valid_i = fv;
    fetch_data_i = fd; pop_i = pp; pop_cnt_i = pc;
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", total - failed, total);
  endtask

  initial begin
    #(PERIOD * 5000);
    total++;
    failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive(1'b0, '0, 1'b0, '0, 1'b0, '0);
    #(PERIOD * 2 + PERIOD / 4);
    // R1 values held during reset
    check(count_o == '0, "R1 count in reset", 64'(count_o), 64'd0);
    check(fetch_addr_o == '0, "R1 address in reset", 64'(fetch_addr_o), 64'd0);
    check(fetch_req_o == 1'b1, "R1 request in reset", 64'(fetch_req_o), 64'd1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(count_o == '0 && fetch_req_o, "R1 after release", 64'(count_o), 64'd0);

    for (int r = 0; r < 17; r++) begin
      drive(VEC[r].fl, VEC[r].fa, VEC[r].fv, VEC[r].fd, VEC[r].pp, VEC[r].pc);
      @(negedge clk);
      check(count_o == VEC[r].ec, "R6/R7/R9/R10 count", 64'(count_o), 64'(VEC[r].ec));
      check(masked(head_bytes_o, VEC[r].ec) == VEC[r].eh, "R6/R9 head bytes",
            64'(masked(head_bytes_o, VEC[r].ec)), 64'(VEC[r].eh));
      check(fetch_addr_o == VEC[r].ea, "R3/R4/R5/R10 fetch address", 64'(fetch_addr_o), 64'(VEC[r].ea));
      check(fetch_req_o == VEC[r].er, "R2 request", 64'(fetch_req_o), 64'(VEC[r].er));
    end

    // Fill to full from even address 0x300
    drive(1'b0, '0, 1'b1, 16'h0102, 1'b0, '0); @(negedge clk);
    drive(1'b0, '0, 1'b1, 16'h0304, 1'b0, '0); @(negedge clk);
    drive(1'b0, '0, 1'b1, 16'h0506, 1'b0, '0); @(negedge clk);
    check(count_o == 3'd6, "R11 full count", 64'(count_o), 64'd6);
    check(head_bytes_o == 48'h050603040102, "R6 full order", 64'(head_bytes_o), 64'h050603040102);
    // R5 word while full is refused
    drive(1'b0, '0, 1'b1, 16'h0708, 1'b0, '0); @(negedge clk);
    check(count_o == 3'd6, "R5 R11 refused when full", 64'(count_o), 64'd6);
    check(head_bytes_o == 48'h050603040102, "R5 head unchanged", 64'(head_bytes_o), 64'h050603040102);
    check(fetch_addr_o == 20'h00306, "R5 address unchanged", 64'(fetch_addr_o), 64'h306);
    // R8 pop of seven is ignored
    drive(1'b0, '0, 1'b0, '0, 1'b1, 3'd7); @(negedge clk);
    check(count_o == 3'd6, "R8 pop seven ignored", 64'(count_o), 64'd6);
    // R7 pop five leaves newest byte at the head
    drive(1'b0, '0, 1'b0, '0, 1'b1, 3'd5); @(negedge clk);
    check(count_o == 3'd1, "R7 pop five count", 64'(count_o), 64'd1);
    check(head_bytes_o[7:0] == 8'h05, "R7 pop five head", 64'(head_bytes_o[7:0]), 64'h05);
    drive(1'b0, '0, 1'b0, '0, 1'b0, '0);
    // R1 asynchronous reset in mid run
    #(PERIOD / 4);
    rst_n = 1'b0;
    #(PERIOD / 8);
    check(count_o == '0, "R1 async reset count", 64'(count_o), 64'd0);
    check(fetch_addr_o == '0, "R1 async reset address", 64'(fetch_addr_o), 64'd0);

    summary();
    $finish;
  end
endmodule